// File: doc/BRIEF.md
# Keyed configuration index-data port

This block is the device side of a two-byte configuration window. A host reaches it through a byte-wide I/O interface: one address bit chooses the index port (0) or the data port (1), with separate write and read strobes. The host first writes a register number to the index port, then reads or writes the data port to reach that register.

The window starts closed. It opens only after the unlock key byte has been written to the index port on two consecutive index writes, and writing the lock key byte to the index port closes it. While closed, the block hides every register. Once open, it offers a logical-device select register and read-only identification registers: a 16-bit device ID, a revision byte and a 16-bit manufacturer ID. Register numbers from the forwarding base upward go to the currently selected logical device over a simple local register bus. The selected device number is driven alongside the bus so that the general-purpose I/O function can sit at whichever device number a given chip family uses.

Top module: `keyed_cfg_window`

## Requirements
- R1: After a synchronous reset the window is closed, `io_rdata` is 0x00, `lb_we` is 0, `lb_wdata` is 0x00, `lb_addr` is 0x00 and `lb_dev` is 0x00.
- R2: The window opens only after 0x87 has been written to the index port on two consecutive index writes. While the window is closed, every read of either port returns 0xFF.
- R3: An index write of any value other than 0x87 while the window is closed cancels unlock progress. The sequence 0x87, other, 0x87 leaves the window closed.
- R4: Writing 0xAA to the index port while the window is open closes it, and later reads return 0xFF. The selected device number is retained.
- R5: Data-port writes while the window is closed have no effect: no local-bus write occurs and the device select value is unchanged.
- R6: Register 0x07 holds the logical-device select. With the window open it is readable and writable through the data port, and its value drives `lb_dev`.
- R7: Register 0x20 reads device ID bits 15:8 (default 0x0A) and register 0x21 reads bits 7:0 (default 0x5C). Register 0x22 reads the revision (default 0x03). Registers 0x23 and 0x24 read 0x19 and 0x34. Writes to these registers change nothing.
- R8: With the window open and an index of 0x30 or above, a data write raises `lb_we` for exactly the next cycle. During that cycle `lb_addr` equals the index, `lb_wdata` equals the written byte and `lb_dev` equals the selected device. A data read of such an index returns `lb_rdata`, sampled in the strobe cycle.
- R9: `io_rdata` is registered: it takes the read value one cycle after a read strobe and holds it until the next strobe. With the window open, an index-port read returns the current index.
- R10: With the window open, data reads of register numbers below 0x30 that are not listed above return 0xFF. Writes to them cause no local-bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_addr | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| lb_dev | output | 8 | Selected logical device number |
| lb_addr | output | 8 | Local-bus register number (current index) |
| lb_wdata | output | 8 | Local-bus write byte |
| lb_we | output | 1 | Local-bus write pulse |
| lb_rdata | input | 8 | Local-bus read byte from the selected device |

## Verification
On every cycle, the assertions check the following properties. A closed window answers reads with 0xFF. The device select does not move while the window is closed. A local-bus write pulse only ever follows an open-window data write. The lock key always closes the window. One key byte seen from the fully locked state never opens the window. The read register holds between strobes. The bench's scenarios show the rest: the complete key sequences, including an interrupted unlock, the identification values, routing to the selected device with the correct address and data, and the 0xFF answer from unmapped registers.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_t;

  // Global register numbers; hosts decode these positions.
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_DID_HI = 8'h20;
  localparam logic [7:0] REG_DID_LO = 8'h21;
  localparam logic [7:0] REG_REV    = 8'h22;
  localparam logic [7:0] REG_MID_HI = 8'h23;
  localparam logic [7:0] REG_MID_LO = 8'h24;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm #(
  parameter int          DW         = 8,
  parameter logic [DW-1:0] UNLOCK_KEY = 8'h87,
  parameter logic [DW-1:0] LOCK_KEY   = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  output logic          open,
  output logic          half
);
  import cfg_pkg::*;

  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (wdata == UNLOCK_KEY) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   state_d = (wdata == UNLOCK_KEY) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   state_d = (wdata == LOCK_KEY)   ? KEY_LOCKED : KEY_OPEN;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KEY_LOCKED;
    else     state_q <= state_d;
  end

  assign open = (state_q == KEY_OPEN);
  assign half = (state_q == KEY_HALF);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs #(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] LOCK_KEY = 8'hAA,
  parameter logic [2*DW-1:0] DEV_ID = 16'h0A5C,
  parameter logic [2*DW-1:0] MAN_ID = 16'h1934,
  parameter logic [DW-1:0] REV_ID   = 8'h03,
  parameter logic [DW-1:0] LDN_RST  = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          open,
  input  logic          idx_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] index,
  output logic [DW-1:0] ldn,
  output logic          glb_hit,
  output logic [DW-1:0] glb_rdata
);
  import cfg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      index <= '0;
      ldn   <= LDN_RST;
    end else begin
      if (idx_wr && open && (wdata != LOCK_KEY)) index <= wdata;
      if (dat_wr && open && (index == DW'(REG_LDN))) ldn <= wdata;
    end
  end

  always_comb begin
    glb_hit   = 1'b1;
    glb_rdata = '1;
    unique case (index)
      DW'(REG_LDN):    glb_rdata = ldn;
      DW'(REG_DID_HI): glb_rdata = DEV_ID[2*DW-1:DW];
      DW'(REG_DID_LO): glb_rdata = DEV_ID[DW-1:0];
      DW'(REG_REV):    glb_rdata = REV_ID;
      DW'(REG_MID_HI): glb_rdata = MAN_ID[2*DW-1:DW];
      DW'(REG_MID_LO): glb_rdata = MAN_ID[DW-1:0];
      default:         glb_hit   = 1'b0;
    endcase
  end
endmodule

// File: rtl/keyed_cfg_window.sv
module keyed_cfg_window #(
  parameter int              DW         = 8,
  parameter logic [DW-1:0]   UNLOCK_KEY = 8'h87,
  parameter logic [DW-1:0]   LOCK_KEY   = 8'hAA,
  parameter logic [2*DW-1:0] DEV_ID     = 16'h0A5C,
  parameter logic [2*DW-1:0] MAN_ID     = 16'h1934,
  parameter logic [DW-1:0]   REV_ID     = 8'h03,
  parameter logic [DW-1:0]   LDN_RST    = 8'h00,
  parameter logic [DW-1:0]   FWD_BASE   = 8'h30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic          io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic [DW-1:0] lb_dev,
  output logic [DW-1:0] lb_addr,
  output logic [DW-1:0] lb_wdata,
  output logic          lb_we,
  input  logic [DW-1:0] lb_rdata
);
  logic          idx_wr, dat_wr;
  logic          key_open, key_half;
  logic [DW-1:0] index, ldn, glb_rdata, rd_val;
  logic          glb_hit, fwd_hit;

  assign idx_wr = io_wr & ~io_addr;
  assign dat_wr = io_wr &  io_addr;

  cfg_key_fsm #(.DW(DW), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_key (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(io_wdata),
    .open(key_open), .half(key_half)
  );

  cfg_global_regs #(
    .DW(DW), .LOCK_KEY(LOCK_KEY), .DEV_ID(DEV_ID), .MAN_ID(MAN_ID),
    .REV_ID(REV_ID), .LDN_RST(LDN_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .open(key_open), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(io_wdata), .index(index), .ldn(ldn),
    .glb_hit(glb_hit), .glb_rdata(glb_rdata)
  );

  assign fwd_hit = (index >= FWD_BASE);

  always_comb begin
    if (!key_open)    rd_val = '1;
    else if (!io_addr) rd_val = index;
    else if (glb_hit) rd_val = glb_rdata;
    else if (fwd_hit) rd_val = lb_rdata;
    else              rd_val = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
      lb_we    <= 1'b0;
      lb_wdata <= '0;
    end else begin
      lb_we <= dat_wr & key_open & fwd_hit;
      if (dat_wr && key_open && fwd_hit) lb_wdata <= io_wdata;
      if (io_rd) io_rdata <= rd_val;
    end
  end

  assign lb_addr = index;
  assign lb_dev  = ldn;
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          io_wr,
  input logic          io_rd,
  input logic          io_addr,
  input logic [DW-1:0] io_wdata,
  input logic [DW-1:0] io_rdata,
  input logic [DW-1:0] lb_dev,
  input logic          lb_we,
  input logic          open,
  input logic          half
);
  p_locked_reads_ff_r2: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !open) |=> (io_rdata == 8'hFF));

  p_single_key_stays_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (!open && !half && io_wr) |=> !open);

  p_lock_key_closes_r4: assert property (@(posedge clk) disable iff (rst)
    (open && io_wr && !io_addr && io_wdata == 8'hAA) |=> !open);

  p_ldn_frozen_locked_r5: assert property (@(posedge clk) disable iff (rst)
    !open |=> $stable(lb_dev));

  p_lbwe_from_open_write_r8: assert property (@(posedge clk) disable iff (rst)
    lb_we |-> $past(io_wr && io_addr && open));

  p_rdata_holds_r9: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));
endmodule

bind keyed_cfg_window cfg_window_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .lb_dev(lb_dev), .lb_we(lb_we),
  .open(key_open), .half(key_half)
);

// File: tb/keyed_cfg_window_bench.sv
module keyed_cfg_window_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata, lb_dev, lb_addr, lb_wdata, lb_rdata;
  logic       lb_we;
  int         n_run = 0, n_fail = 0;

  // Device model: read byte depends on address and selected device.
  assign lb_rdata = lb_addr + lb_dev;

  keyed_cfg_window u_keyed_cfg_window (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .lb_dev(lb_dev),
    .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_we(lb_we), .lb_rdata(lb_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic rdreg(input logic [7:0] r, output logic [7:0] d);
    wr(1'b0, r); rd(1'b1, d);
  endtask

  task automatic unlock();
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
  endtask

  task automatic t_reset();
    chk("R1 io_rdata", io_rdata, 8'h00);
    chk("R1 lb_we", {7'b0, lb_we}, 8'h00);
    chk("R1 lb_wdata", lb_wdata, 8'h00);
    chk("R1 lb_addr", lb_addr, 8'h00);
    chk("R1 lb_dev", lb_dev, 8'h00);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    rd(1'b1, v); chk("R2 locked data read", v, 8'hFF);
    rd(1'b0, v); chk("R2 locked index read", v, 8'hFF);
    wr(1'b0, 8'h07); wr(1'b1, 8'h55);
    chk("R5 no lb_we when locked", {7'b0, lb_we}, 8'h00);
    wr(1'b0, 8'h31); wr(1'b1, 8'h66);
    chk("R5 no forwarded write when locked", {7'b0, lb_we}, 8'h00);
    chk("R5 lb_dev unchanged", lb_dev, 8'h00);
  endtask

  task automatic t_partial_key();
    logic [7:0] v;
    wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
    wr(1'b0, 8'h20); rd(1'b1, v);
    chk("R3 interrupted key stays locked", v, 8'hFF);
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h87); wr(1'b0, 8'h20); rd(1'b1, v);
    chk("R3 single key stays locked", v, 8'hFF);
  endtask

  task automatic t_unlock_ldn();
    logic [7:0] v;
    wr(1'b0, 8'h33);
    unlock();
    rdreg(8'h07, v); chk("R6 ldn read after reset", v, 8'h00);
    rd(1'b0, v); chk("R9 index port readback", v, 8'h07);
    wr(1'b1, 8'h06);
    chk("R6 lb_dev follows select", lb_dev, 8'h06);
    rd(1'b1, v); chk("R6 ldn readback", v, 8'h06);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    rdreg(8'h20, v); chk("R7 device id high", v, 8'h0A);
    rdreg(8'h21, v); chk("R7 device id low", v, 8'h5C);
    rdreg(8'h22, v); chk("R7 revision", v, 8'h03);
    rdreg(8'h23, v); chk("R7 manufacturer high", v, 8'h19);
    rdreg(8'h24, v); chk("R7 manufacturer low", v, 8'h34);
    wr(1'b0, 8'h21); wr(1'b1, 8'hFF);
    chk("R7 id write not forwarded", {7'b0, lb_we}, 8'h00);
    rd(1'b1, v); chk("R7 id write ignored", v, 8'h5C);
  endtask

  task automatic t_forward();
    logic [7:0] v;
    wr(1'b0, 8'h30); wr(1'b1, 8'hC3);
    chk("R8 lb_we pulse", {7'b0, lb_we}, 8'h01);
    chk("R8 lb_addr", lb_addr, 8'h30);
    chk("R8 lb_wdata", lb_wdata, 8'hC3);
    chk("R8 lb_dev", lb_dev, 8'h06);
    @(negedge clk);
    chk("R8 lb_we single cycle", {7'b0, lb_we}, 8'h00);
    wr(1'b0, 8'hF0); rd(1'b1, v);
    chk("R8 forwarded read", v, 8'hF6);
    repeat (3) @(negedge clk);
    chk("R9 rdata holds", io_rdata, 8'hF6);
    wr(1'b0, 8'h07); wr(1'b1, 8'h07);
    wr(1'b0, 8'h31); rd(1'b1, v);
    chk("R8 read routed to new device", v, 8'h38);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    rdreg(8'h2F, v); chk("R10 unmapped read 2F", v, 8'hFF);
    rdreg(8'h00, v); chk("R10 unmapped read 00", v, 8'hFF);
    wr(1'b1, 8'h44);
    chk("R10 unmapped write not forwarded", {7'b0, lb_we}, 8'h00);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h20); rd(1'b1, v);
    chk("R4 closed after lock key", v, 8'hFF);
    chk("R4 device select retained", lb_dev, 8'h07);
    unlock();
    rdreg(8'h07, v); chk("R4 select retained after reopen", v, 8'h07);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked();
        t_partial_key();
        t_unlock_ldn();
        t_ids();
        t_forward();
        t_unmapped();
        t_lock();
      end
      begin
        repeat (20000) @(negedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule